// File: doc/BRIEF.md
# PLL Configuration Word Calculator

This block turns a reference clock frequency and a wanted PLL output rate, both given in kHz as unsigned integers, into a packed 16-bit PLL setup word. It selects an input pre-divider, works out a feedback multiplier rounded upward, computes the output rate that this pair actually produces, and classifies that rate into a 2-bit band code. It also derives a 6-bit divider field for a low-power escape clock from the produced rate.

A caller presents both frequencies and pulses `start`. The block works for a data-dependent number of cycles: a short linear search for the pre-divider, then three passes through one shared bit-serial restoring divider. After that it pulses `done` for one cycle, with the results on its outputs. The results stay unchanged until the next computation finishes, and `start` is ignored while a computation is running.

Top module: `pll_word_calc`

## Requirements
- R1: After reset `done` and `err` are 0 and `cfg_word`, `rate_khz` and `lp_div` are all zero.
- R2: The pre-divider D in `cfg_word[13:8]` starts at 1 and grows for as long as `ref_khz / (D+1)`, rounded down, is at least 2000. It is the largest such value, and is 1 when even D=2 fails.
- R3: D never exceeds 31. For a large reference the search stops at 31.
- R4: The multiplier M in `cfg_word[7:0]` is the ceiling of `want_khz * D / ref_khz`.
- R5: M saturates at 255 when the ceiling would be larger, so the D field is never disturbed.
- R6: `rate_khz` equals `ref_khz * M / D` rounded down. It uses the saturated M.
- R7: The band code in `cfg_word[15:14]` is 3 when `rate_khz` is at least 501000, 2 when it is at least 251000, 1 when it is at least 126000, and 0 otherwise.
- R8: `lp_div` equals `(rate_khz / 40000) - 1` modulo 64, so a quotient of 0 gives 63.
- R9: A `start` with `ref_khz` equal to 0 sets `err`, clears `cfg_word`, `rate_khz` and `lp_div`, and pulses `done` with no search or division. A later valid computation clears `err`.
- R10: `done` is high for exactly one cycle per accepted `start`. The outputs change only in that cycle. A `start` that arrives while a computation is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation (sampled only when idle) |
| ref_khz | input | 32 | Reference frequency in kHz |
| want_khz | input | 32 | Wanted PLL output rate in kHz |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Set when the last request had a zero reference |
| cfg_word | output | 16 | {band[1:0], pre-divider[5:0], multiplier[7:0]} |
| rate_khz | output | 40 | Produced output rate in kHz |
| lp_div | output | 6 | Low-power clock divider field |

## Verification
Any wrong internal state shows up in the one word reported at `done`. If the search stops one step early or late, the divider field is off by one. That error then spreads into the multiplier, the rate, the band and the low-power field. A slip in the serial divider, such as a lost bit or a wrong restore, shows as a wrong quotient in the rate or the multiplier. Both effects are visible in the `done` cycle, no more than about 160 cycles after `start`. The bench therefore compares every field against a model computed from the rules above. Control faults show at once: a late second `done`, or an output that moves outside the `done` cycle.

// File: rtl/pllw_pkg.sv
package pllw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEARCH,
      ST_MUL_GO,
      ST_MUL_WAIT,
      ST_RATE_GO,
      ST_RATE_WAIT,
      ST_LP_GO,
      ST_LP_WAIT
   } calc_state_t;

   // Lower edge of band i+1, in kHz; band count follows the code width.
   function automatic int unsigned band_edge_khz(input int idx);
      case (idx)
         0:       band_edge_khz = 126000;
         1:       band_edge_khz = 251000;
         2:       band_edge_khz = 501000;
         default: band_edge_khz = 501000 + (idx - 2) * 250000;
      endcase
   endfunction

endpackage

// File: rtl/pllw_serial_div.sv
module pllw_serial_div #(
   parameter int NUM_W = 40,
   parameter int DEN_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             fin,
   output logic [NUM_W-1:0] quo,
   output logic [DEN_W-1:0] rem
);
   localparam int CNT_W  = $clog2(NUM_W + 1);
   localparam int PROD_W = NUM_W + DEN_W;

   logic [NUM_W-1:0] work_q;
   logic [DEN_W-1:0] rem_q;
   logic [DEN_W-1:0] den_q;
   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic             fin_q;

   logic [DEN_W:0]   trial;
   logic [DEN_W:0]   diff;
   logic             fits;

   always_comb begin
      trial = {rem_q, work_q[NUM_W-1]};
      diff  = trial - {1'b0, den_q};
      fits  = (trial >= {1'b0, den_q});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work_q <= '0;
         rem_q  <= '0;
         den_q  <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         fin_q  <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         if (go && !run_q) begin
            work_q <= num;
            rem_q  <= '0;
            den_q  <= den;
            cnt_q  <= CNT_W'(NUM_W);
            run_q  <= 1'b1;
         end else if (run_q) begin
            rem_q  <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
            work_q <= {work_q[NUM_W-2:0], fits};
            cnt_q  <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
               run_q <= 1'b0;
               fin_q <= 1'b1;
            end
         end
      end
   end

   assign fin = fin_q;
   assign quo = work_q;
   assign rem = rem_q;

   // Checker state: dividend seen at launch.
   logic [NUM_W-1:0] num_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              num_seen <= '0;
      else if (go && !run_q)   num_seen <= num;
   end

   // R4 R6 R8: each serial division is exact
   a_r4_div_exact: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> (PROD_W'(quo) * PROD_W'(den_q) + PROD_W'(rem) == PROD_W'(num_seen)));
   a_r4_rem_small: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> (rem < den_q));
endmodule

// File: rtl/pllw_band.sv
module pllw_band
   import pllw_pkg::*;
#(
   parameter int RATE_W  = 40,
   parameter int RANGE_W = 2
) (
   input  logic [RATE_W-1:0]  rate,
   output logic [RANGE_W-1:0] band
);
   localparam int N_EDGE = (1 << RANGE_W) - 1;

   logic [N_EDGE-1:0] above;

   for (genvar i = 0; i < N_EDGE; i++) begin : g_edge
      assign above[i] = (rate >= RATE_W'(band_edge_khz(i)));
   end

   always_comb begin
      band = '0;
      for (int i = 0; i < N_EDGE; i++) begin
         if (above[i]) band = RANGE_W'(i + 1);
      end
   end
endmodule

// File: rtl/pllw_pack.sv
module pllw_pack #(
   parameter int RANGE_W = 2,
   parameter int DIVF_W  = 6,
   parameter int MUL_W   = 8,
   parameter int LP_W    = 6,
   parameter int RATE_W  = 40,
   localparam int WORD_W = RANGE_W + DIVF_W + MUL_W
) (
   input  logic [RANGE_W-1:0] band,
   input  logic [DIVF_W-1:0]  pre_div,
   input  logic [MUL_W-1:0]   fb_mul,
   input  logic [RATE_W-1:0]  lp_quo,
   output logic [WORD_W-1:0]  word,
   output logic [LP_W-1:0]    lp_field
);
   assign word     = {band, pre_div, fb_mul};
   assign lp_field = lp_quo[LP_W-1:0] - LP_W'(1);
endmodule

// File: rtl/pll_word_calc.sv
module pll_word_calc
   import pllw_pkg::*;
#(
   parameter int FREQ_W      = 32,
   parameter int MUL_W       = 8,
   parameter int DIVF_W      = 6,
   parameter int RANGE_W     = 2,
   parameter int LP_W        = 6,
   parameter int DIV_MAX     = 31,
   parameter int FLOOR_KHZ   = 2000,
   parameter int LP_STEP_KHZ = 40000,
   localparam int WORD_W     = RANGE_W + DIVF_W + MUL_W,
   localparam int RATE_W     = FREQ_W + MUL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [FREQ_W-1:0] ref_khz,
   input  logic [FREQ_W-1:0] want_khz,
   output logic              done,
   output logic              err,
   output logic [WORD_W-1:0] cfg_word,
   output logic [RATE_W-1:0] rate_khz,
   output logic [LP_W-1:0]   lp_div
);
   localparam int MUL_MAX = (1 << MUL_W) - 1;

   initial begin
      assert (DIV_MAX >= 1 && DIV_MAX < (1 << DIVF_W))
         else $fatal(1, "DIV_MAX does not fit the divider field");
      assert ($clog2(DIV_MAX + 1) <= MUL_W)
         else $fatal(1, "product width too small for DIV_MAX");
      assert (FLOOR_KHZ > 0 && LP_STEP_KHZ > 0)
         else $fatal(1, "floor and low-power step must be positive");
      assert (RANGE_W >= 1 && LP_W >= 1)
         else $fatal(1, "field widths must be positive");
   end

   calc_state_t       st_q;
   logic [FREQ_W-1:0] ref_q;
   logic [FREQ_W-1:0] want_q;
   logic [DIVF_W-1:0] pdiv_q;
   logic [RATE_W-1:0] thr_q;
   logic [MUL_W-1:0]  mul_q;
   logic [RATE_W-1:0] rate_q;

   logic              done_q;
   logic              err_q;
   logic [WORD_W-1:0] word_q;
   logic [RATE_W-1:0] rate_out_q;
   logic [LP_W-1:0]   lp_q;

   // Shared divider operands
   logic              dv_go;
   logic [RATE_W-1:0] dv_num;
   logic [FREQ_W-1:0] dv_den;
   logic              dv_fin;
   logic [RATE_W-1:0] dv_quo;
   logic [FREQ_W-1:0] dv_rem;

   always_comb begin
      dv_go  = 1'b0;
      dv_num = '0;
      dv_den = ref_q;
      case (st_q)
         ST_MUL_GO: begin
            dv_go  = 1'b1;
            dv_num = RATE_W'(want_q) * RATE_W'(pdiv_q);
            dv_den = ref_q;
         end
         ST_RATE_GO: begin
            dv_go  = 1'b1;
            dv_num = RATE_W'(ref_q) * RATE_W'(mul_q);
            dv_den = FREQ_W'(pdiv_q);
         end
         ST_LP_GO: begin
            dv_go  = 1'b1;
            dv_num = rate_q;
            dv_den = FREQ_W'(LP_STEP_KHZ);
         end
         default: ;
      endcase
   end

   pllw_serial_div #(
      .NUM_W (RATE_W),
      .DEN_W (FREQ_W)
   ) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (dv_go),
      .num   (dv_num),
      .den   (dv_den),
      .fin   (dv_fin),
      .quo   (dv_quo),
      .rem   (dv_rem)
   );

   // Ceiling and saturation of the multiplier quotient
   logic [RATE_W-1:0] mul_ceil;
   logic [MUL_W-1:0]  mul_sat;
   always_comb begin
      mul_ceil = dv_quo + RATE_W'(dv_rem != '0);
      mul_sat  = (mul_ceil > RATE_W'(MUL_MAX)) ? MUL_W'(MUL_MAX) : mul_ceil[MUL_W-1:0];
   end

   logic              search_step;
   assign search_step = (pdiv_q < DIVF_W'(DIV_MAX)) && (RATE_W'(ref_q) >= thr_q);

   logic [RANGE_W-1:0] band;
   logic [WORD_W-1:0]  word_nx;
   logic [LP_W-1:0]    lp_nx;

   pllw_band #(
      .RATE_W  (RATE_W),
      .RANGE_W (RANGE_W)
   ) u_band (
      .rate (rate_q),
      .band (band)
   );

   pllw_pack #(
      .RANGE_W (RANGE_W),
      .DIVF_W  (DIVF_W),
      .MUL_W   (MUL_W),
      .LP_W    (LP_W),
      .RATE_W  (RATE_W)
   ) u_pack (
      .band     (band),
      .pre_div  (pdiv_q),
      .fb_mul   (mul_q),
      .lp_quo   (dv_quo),
      .word     (word_nx),
      .lp_field (lp_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         ref_q      <= '0;
         want_q     <= '0;
         pdiv_q     <= '0;
         thr_q      <= '0;
         mul_q      <= '0;
         rate_q     <= '0;
         done_q     <= 1'b0;
         err_q      <= 1'b0;
         word_q     <= '0;
         rate_out_q <= '0;
         lp_q       <= '0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  if (ref_khz == '0) begin
                     err_q      <= 1'b1;
                     done_q     <= 1'b1;
                     word_q     <= '0;
                     rate_out_q <= '0;
                     lp_q       <= '0;
                  end else begin
                     ref_q  <= ref_khz;
                     want_q <= want_khz;
                     pdiv_q <= DIVF_W'(1);
                     thr_q  <= RATE_W'(2 * FLOOR_KHZ);
                     st_q   <= ST_SEARCH;
                  end
               end
            end
            ST_SEARCH: begin
               if (search_step) begin
                  pdiv_q <= pdiv_q + 1'b1;
                  thr_q  <= thr_q + RATE_W'(FLOOR_KHZ);
               end else begin
                  st_q <= ST_MUL_GO;
               end
            end
            ST_MUL_GO:  st_q <= ST_MUL_WAIT;
            ST_MUL_WAIT: begin
               if (dv_fin) begin
                  mul_q <= mul_sat;
                  st_q  <= ST_RATE_GO;
               end
            end
            ST_RATE_GO: st_q <= ST_RATE_WAIT;
            ST_RATE_WAIT: begin
               if (dv_fin) begin
                  rate_q <= dv_quo;
                  st_q   <= ST_LP_GO;
               end
            end
            ST_LP_GO:   st_q <= ST_LP_WAIT;
            ST_LP_WAIT: begin
               if (dv_fin) begin
                  word_q     <= word_nx;
                  rate_out_q <= rate_q;
                  lp_q       <= lp_nx;
                  err_q      <= 1'b0;
                  done_q     <= 1'b1;
                  st_q       <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign done     = done_q;
   assign err      = err_q;
   assign cfg_word = word_q;
   assign rate_khz = rate_out_q;
   assign lp_div   = lp_q;

   // R10: completion is a single-cycle pulse
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R10: outputs move only in the completion cycle
   a_r10_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(cfg_word) && $stable(rate_khz) && $stable(lp_div) && $stable(err)));
   // R3: divider field never exceeds its limit and is non-zero on success
   a_r3_div_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err) |-> (cfg_word[MUL_W +: DIVF_W] <= DIVF_W'(DIV_MAX)
                          && cfg_word[MUL_W +: DIVF_W] != '0));
   // R2: a divider above 1 keeps the divided reference at the floor
   a_r2_floor_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err && cfg_word[MUL_W +: DIVF_W] > DIVF_W'(1))
         |-> (RATE_W'(ref_q) >= RATE_W'(FLOOR_KHZ) * RATE_W'(cfg_word[MUL_W +: DIVF_W])));
   // R9: zero reference reports a cleared result
   a_r9_zero_ref: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> (cfg_word == '0 && rate_khz == '0 && lp_div == '0));
   // R7: a rate below the first edge lands in band 0
   a_r7_low_band: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err && rate_khz < RATE_W'(band_edge_khz(0)))
         |-> (cfg_word[WORD_W-1 -: RANGE_W] == '0));
endmodule

// File: tb/sim_pll_word_calc.sv
module sim_pll_word_calc;
   localparam int CLK_NS = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] ref_khz = '0;
   logic [31:0] want_khz = '0;
   logic        done;
   logic        err;
   logic [15:0] cfg_word;
   logic [39:0] rate_khz;
   logic [5:0]  lp_div;

   int checks = 0;
   int failures = 0;

   always #(CLK_NS / 2) clk = ~clk;

   pll_word_calc u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .ref_khz  (ref_khz),
      .want_khz (want_khz),
      .done     (done),
      .err      (err),
      .cfg_word (cfg_word),
      .rate_khz (rate_khz),
      .lp_div   (lp_div)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Reference model built from the requirement text
   task automatic model(input longint r, input longint w,
                        output longint d, output longint m,
                        output longint rate, output longint band,
                        output longint lp);
      d = 1;
      while (r / (d + 1) >= 2000) d++;
      if (d > 31) d = 31;
      m = (w * d + r - 1) / r;
      if (m > 255) m = 255;
      rate = r * m / d;
      if (rate >= 501000)      band = 3;
      else if (rate >= 251000) band = 2;
      else if (rate >= 126000) band = 1;
      else                     band = 0;
      lp = ((rate / 40000) - 1) & 63;
   endtask

   // Pulse start and wait for done; returns at the negedge where done is seen
   task automatic launch(input logic [31:0] r, input logic [31:0] w, output bit seen);
      int n;
      @(negedge clk);
      ref_khz  = r;
      want_khz = w;
      start    = 1'b1;
      @(negedge clk);
      start = 1'b0;
      seen  = 1'b0;
      n     = 0;
      while (!done && n < 2000) begin
         @(negedge clk);
         n++;
      end
      seen = done;
   endtask

   task automatic run_case(input string name, input logic [31:0] r, input logic [31:0] w,
                           input string dreq);
      bit seen;
      longint d, m, rate, band, lp;
      model(r, w, d, m, rate, band, lp);
      launch(r, w, seen);
      chk(seen, "R10", {name, " done seen"}, longint'(seen), 1);
      chk(cfg_word[13:8] == d[5:0], dreq, {name, " divider"}, longint'(cfg_word[13:8]), d);
      chk(cfg_word[7:0] == m[7:0], "R4", {name, " multiplier"}, longint'(cfg_word[7:0]), m);
      chk(rate_khz == rate[39:0], "R6", {name, " rate"}, longint'(rate_khz), rate);
      chk(cfg_word[15:14] == band[1:0], "R7", {name, " band"}, longint'(cfg_word[15:14]), band);
      chk(lp_div == lp[5:0], "R8", {name, " lp field"}, longint'(lp_div), lp);
      chk(err == 1'b0, "R9", {name, " err clear"}, longint'(err), 0);
      @(negedge clk);
      chk(done == 1'b0, "R10", {name, " done one cycle"}, longint'(done), 0);
   endtask

   task automatic t_reset();
      chk(done == 1'b0, "R1", "reset done", longint'(done), 0);
      chk(err == 1'b0, "R1", "reset err", longint'(err), 0);
      chk(cfg_word == 16'h0, "R1", "reset word", longint'(cfg_word), 0);
      chk(rate_khz == 40'h0 && lp_div == 6'h0, "R1", "reset rate/lp",
          longint'(rate_khz), 0);
   endtask

   task automatic t_saturate();
      longint d, m, rate, band, lp;
      model(2000, 1000000, d, m, rate, band, lp);
      run_case("saturate", 32'd2000, 32'd1000000, "R2");
      chk(cfg_word[7:0] == 8'd255 && m == 255, "R5", "multiplier saturates",
          longint'(cfg_word[7:0]), 255);
      chk(cfg_word[13:8] == 6'd1, "R5", "divider field undisturbed",
          longint'(cfg_word[13:8]), 1);
   endtask

   task automatic t_clamp();
      run_case("clamp", 32'd200000, 32'd400000, "R3");
      chk(cfg_word[13:8] == 6'd31, "R3", "divider clamped at 31",
          longint'(cfg_word[13:8]), 31);
   endtask

   task automatic t_zero_ref();
      bit seen;
      launch(32'd0, 32'd300000, seen);
      chk(seen, "R9", "zero ref done", longint'(seen), 1);
      chk(err == 1'b1, "R9", "zero ref err", longint'(err), 1);
      chk(cfg_word == 16'h0 && rate_khz == 40'h0 && lp_div == 6'h0, "R9",
          "zero ref outputs cleared", longint'(cfg_word), 0);
      @(negedge clk);
      chk(done == 1'b0, "R10", "zero ref done one cycle", longint'(done), 0);
      run_case("after error", 32'd24000, 32'd300000, "R2");
   endtask

   task automatic t_busy_ignore();
      bit seen;
      int n;
      longint d, m, rate, band, lp;
      logic [15:0] w0;
      model(19200, 480000, d, m, rate, band, lp);
      @(negedge clk);
      ref_khz  = 32'd19200;
      want_khz = 32'd480000;
      start    = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      ref_khz  = 32'd50000;
      want_khz = 32'd90000;
      start    = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 0;
      while (!done && n < 2000) begin
         @(negedge clk);
         n++;
      end
      seen = done;
      chk(seen, "R10", "busy run done", longint'(seen), 1);
      chk(cfg_word[13:8] == d[5:0] && cfg_word[7:0] == m[7:0], "R10",
          "start while busy ignored", longint'(cfg_word), (band << 14) | (d << 8) | m);
      w0 = cfg_word;
      n = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (done) n++;
      end
      chk(n == 0, "R10", "no second done", n, 0);
      chk(cfg_word == w0, "R10", "outputs held", longint'(cfg_word), longint'(w0));
   endtask

   initial begin
      #(CLK_NS * 200000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      run_case("typical", 32'd24000, 32'd300000, "R2");
      run_case("low band", 32'd13000, 32'd100000, "R2");
      run_case("mid band", 32'd27000, 32'd150000, "R2");
      run_case("small ref", 32'd1500, 32'd50000, "R2");
      run_case("exact floor", 32'd4000, 32'd260000, "R2");
      run_case("zero want", 32'd26000, 32'd0, "R2");
      t_saturate();
      t_clamp();
      t_zero_ref();
      t_busy_ignore();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule